// File: doc/BRIEF.md
# Interrupt Signalling and Reset Control Register

This block is a small control register in a board's glue logic. A host CPU reaches it through single-cycle select and write strobes on a 16-bit data path. Only the low four bits hold state. Two of them decide how a new board interrupt reaches the CPU on one output line. In level mode, each new interrupt inverts the line. In pulse mode, the line drops low for a fixed 1.12 µs pulse and then returns high by itself. A rearm option makes an interrupt that stays pending fire again. The other two bits control resets. One blocks the board-wide reset so the CPU can enter sleep without being reset. The other forces the reset of a removable storage card slot.

Several interrupt source lines come in asynchronously. Each is passed through a two-flop synchroniser. A rising edge on any source, compared with the previous synchronised sample, counts as one new interrupt event. The pulse width is a cycle count worked out from the clock frequency parameter. An event that arrives while a pulse is running is held. It starts a new pulse once the line has been high for one cycle.

Top module: `irq_rst_ctrl`

## Requirements
- R1: After the synchronous active-low reset, the register reads 0x0000, `irq_out` is high, and neither reset output is driven by the register.
- R2: A write happens only when `bus_sel` and `bus_wr` are both high. Only `bus_wdata[3:0]` is stored, and bits 15 to 4 are ignored. While `bus_sel` is high, `bus_rdata` returns the stored nibble in bits 3:0 with zeros above it. While `bus_sel` is low, `bus_rdata` is zero. Bit 0 is the rearm enable, bit 1 selects pulse mode, bit 2 blocks the board reset and bit 3 forces the card reset.
- R3: In level mode (bit 1 = 0), a rising edge on any source inverts `irq_out`. The change appears on the third rising clock edge after the source changes, and not before.
- R4: In level mode with rearm off, `irq_out` holds its level while a source stays high. Nothing clears it automatically.
- R5: In pulse mode (bit 1 = 1), `irq_out` is high when idle. A new event drives it low from the third clock edge after the source edge, for exactly PULSE_CYC cycles. PULSE_CYC is CLK_HZ × 1.12 µs, rounded to the nearest cycle, which gives 280 at 250 MHz.
- R6: In pulse mode, any events that arrive during a pulse are merged into one held event. When the pulse ends, `irq_out` is high for exactly one cycle and then a single new pulse starts.
- R7: With bit 0 set, a source that stays high raises a new event every RETRIG_CYC cycles. With bit 0 clear, a source held high raises no further event.
- R8: `board_rst_out` follows `board_rst_req` while bit 2 is 0, and is held low while bit 2 is 1.
- R9: `card_rst_out` is high whenever bit 3 is 1. Otherwise it follows `board_rst_out`.
- R10: A falling edge on a source raises no event. Rising edges on several sources in the same cycle raise exactly one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register select strobe |
| bus_wr | input | 1 | Write strobe, used while selected |
| bus_wdata | input | 16 | Write data; only bits 3:0 are used |
| bus_rdata | output | 16 | Read data; the nibble while selected, zero otherwise |
| irq_src | input | N_SRC | Asynchronous interrupt source lines, active high |
| irq_out | output | 1 | Interrupt line to the CPU |
| board_rst_req | input | 1 | Board reset request, active high |
| board_rst_out | output | 1 | Gated board reset, active high |
| card_rst_out | output | 1 | Card slot reset, active high |

## Verification
The assertions assume that `rst_n` is held low for at least two clock edges. This lets every register reach its reset value before any `$past` term is used. The assertions also assume that the bus strobes and `board_rst_req` are never unknown outside reset. The bench drives every input to a known value at time zero and holds reset for five cycles. It changes inputs only one time unit after a rising edge, and clears all sources before it changes the mode bits. As a result, each event in the bench can be traced to one source edge or one rearm interval.

// File: rtl/irq_rst_ctrl_pkg.sv
// Shared types for the interrupt signalling and reset control register.
// Assumes nothing; only declares the control nibble layout.
package irq_rst_ctrl_pkg;

    // Control nibble: field order sets the bit position software uses.
    typedef struct packed {
        logic card_rst_force;   // bit 3
        logic rst_block;        // bit 2
        logic pulse_mode;       // bit 1
        logic rearm_en;         // bit 0
    } ctl_t;

    localparam int unsigned CTL_W  = $bits(ctl_t);
    localparam int unsigned BUS_W  = 16;

endpackage

// File: rtl/irq_rst_ctrl_regs.sv
// Control register with single-cycle select/write strobes.
// Does: stores the low nibble of a write and returns it on reads.
// Assumes: strobes are synchronous to clk; the upper write lanes carry no state.
module irq_rst_ctrl_regs
    import irq_rst_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output ctl_t             ctl
);

    localparam int unsigned PAD_W = BUS_W - CTL_W;

    logic wr_hit;
    logic unused_hi;

    assign wr_hit    = bus_sel & bus_wr;
    assign unused_hi = ^bus_wdata[BUS_W-1:CTL_W];

    // Capture the control nibble on a selected write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr_hit) begin
            ctl <= ctl_t'(bus_wdata[CTL_W-1:0]);
        end
    end

    // Return the nibble zero-extended while selected.
    always_comb begin
        if (bus_sel) begin
            bus_rdata = {{PAD_W{1'b0}}, ctl};
        end else begin
            bus_rdata = '0;
        end
    end

    // A selected write is visible on the next cycle's read data.
    p_write_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && $past(bus_sel && bus_wr)) |-> (bus_rdata[CTL_W-1:0] == $past(bus_wdata[CTL_W-1:0])));

    // Without a selected write the nibble does not move.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> $stable(ctl));

endmodule

// File: rtl/irq_rst_ctrl_detect.sv
// Interrupt source front end.
// Does: synchronises each source with two flops and flags one event per cycle
// in which any bit rises. While rearm is enabled and a source stays high, it
// also flags an event every RETRIG_CYC cycles.
// Assumes: sources may be asynchronous; RETRIG_CYC >= 1.
module irq_rst_ctrl_detect #(
    parameter int unsigned N_SRC      = 4,
    parameter int unsigned RETRIG_CYC = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_src,
    input  logic             rearm_en,
    output logic             evt
);

    localparam int unsigned RCW = $clog2(RETRIG_CYC + 1);
    localparam logic [RCW-1:0] RT_LAST = RCW'(RETRIG_CYC - 1);

    logic [N_SRC-1:0] src_sync;
    logic [N_SRC-1:0] src_prev;
    logic [RCW-1:0]   rt_cnt;
    logic             new_edge;
    logic             pending;
    logic             rearm_fire;

    // One two-flop synchroniser for each source bit.
    for (genvar i = 0; i < N_SRC; i++) begin : g_sync
        logic meta_q;
        logic sync_q;
        // Two-stage capture of one asynchronous source bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= irq_src[i];
                sync_q <= meta_q;
            end
        end
        assign src_sync[i] = sync_q;
    end

    // Keep the previous synchronised vector for the edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_prev <= '0;
        end else begin
            src_prev <= src_sync;
        end
    end

    assign new_edge   = |(src_sync & ~src_prev);
    assign pending    = |src_sync;
    assign rearm_fire = rearm_en && pending && !new_edge && (rt_cnt == RT_LAST);

    // Count the rearm interval while a source stays pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_cnt <= '0;
        end else if (!rearm_en || !pending || new_edge || rearm_fire) begin
            rt_cnt <= '0;
        end else begin
            rt_cnt <= rt_cnt + 1'b1;
        end
    end

    assign evt = new_edge | rearm_fire;

    // With rearm off, a pending source never fires again.
    p_rearm_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rearm_en |-> !rearm_fire);

    // With every synchronised source low, no event is raised.
    p_idle_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sync == '0) |-> !evt);

    // The interval counter never passes its last value.
    p_rt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rt_cnt <= RT_LAST);

endmodule

// File: rtl/irq_rst_ctrl_signal.sv
// Interrupt line driver.
// Does: in level mode, inverts a held level on each event. In pulse mode,
// drives a low pulse of PULSE_CYC cycles and holds one event that arrives
// during a pulse.
// Assumes: evt is a single-cycle strobe; PULSE_CYC >= 1.
module irq_rst_ctrl_signal #(
    parameter int unsigned PULSE_CYC = 280
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_mode,
    input  logic evt,
    output logic irq_out
);

    localparam int unsigned PCW = $clog2(PULSE_CYC + 1);
    localparam logic [PCW-1:0] P_LOAD = PCW'(PULSE_CYC);

    logic           lvl_q;
    logic [PCW-1:0] pulse_cnt;
    logic           held_q;
    logic           pulse_idle;

    assign pulse_idle = (pulse_cnt == '0);

    // Level mode: invert the line on every event; idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b1;
        end else if (!pulse_mode && evt) begin
            lvl_q <= ~lvl_q;
        end
    end

    // Pulse mode: run the width counter and start held events.
    always_ff @(posedge clk) begin
        if (!rst_n || !pulse_mode) begin
            pulse_cnt <= '0;
            held_q    <= 1'b0;
        end else if (!pulse_idle) begin
            pulse_cnt <= pulse_cnt - 1'b1;
            if (evt) begin
                held_q <= 1'b1;
            end
        end else if (evt || held_q) begin
            pulse_cnt <= P_LOAD;
            held_q    <= 1'b0;
        end
    end

    // Select the line source for the active mode.
    always_comb begin
        irq_out = pulse_mode ? pulse_idle : lvl_q;
    end

    // Level mode: an event inverts the line on the next cycle.
    p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && $past(!pulse_mode) && $past(evt)) |-> (irq_out != $past(irq_out)));

    // Level mode: without an event the line holds.
    p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && $past(!pulse_mode) && !$past(evt)) |-> $stable(irq_out));

    // A falling line in pulse mode always starts a full-width count.
    p_pulse_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && $past(pulse_mode) && $fell(irq_out)) |-> (pulse_cnt == P_LOAD));

    // A held event starts a pulse on the first idle cycle.
    p_held_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && pulse_idle && held_q) |=> (!irq_out || !pulse_mode));

endmodule

// File: rtl/irq_rst_ctrl_rstgate.sv
// Reset gating.
// Does: blocks the board reset while the block bit is set, and forces the
// card reset or lets it follow the gated board reset.
// Assumes: all resets are active high; the request is already synchronous.
module irq_rst_ctrl_rstgate (
    input  logic clk,
    input  logic rst_n,
    input  logic board_rst_req,
    input  logic rst_block,
    input  logic card_rst_force,
    output logic board_rst_out,
    output logic card_rst_out
);

    // Combine the request and the control bits into both reset outputs.
    always_comb begin
        board_rst_out = board_rst_req & ~rst_block;
        card_rst_out  = card_rst_force | board_rst_out;
    end

    // A blocked board reset never leaves the block.
    p_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_block |-> !board_rst_out);

    // A forced card reset is always asserted.
    p_card_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst_force |-> card_rst_out);

    // A passed board reset always reaches the card.
    p_card_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        board_rst_out |-> card_rst_out);

endmodule

// File: rtl/irq_rst_ctrl.sv
// Interrupt signalling and reset control register, top level.
// Does: ties the control register, the source edge detector, the line driver
// and the reset gate together.
// Assumes: one clock domain; sources are synchronised inside.
module irq_rst_ctrl
    import irq_rst_ctrl_pkg::*;
#(
    parameter int unsigned N_SRC      = 4,
    parameter longint unsigned CLK_HZ = 250_000_000,
    parameter int unsigned RETRIG_CYC = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [15:0]      bus_wdata,
    output logic [15:0]      bus_rdata,
    input  logic [N_SRC-1:0] irq_src,
    output logic             irq_out,
    input  logic             board_rst_req,
    output logic             board_rst_out,
    output logic             card_rst_out
);

    localparam longint unsigned PULSE_CYC_L =
        (CLK_HZ * 64'd112 + 64'd50_000_000) / 64'd100_000_000;
    localparam int unsigned PULSE_CYC = (PULSE_CYC_L == 0) ? 1 : int'(PULSE_CYC_L);

    ctl_t ctl;
    logic evt;

    irq_rst_ctrl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctl       (ctl)
    );

    irq_rst_ctrl_detect #(
        .N_SRC      (N_SRC),
        .RETRIG_CYC (RETRIG_CYC)
    ) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_src  (irq_src),
        .rearm_en (ctl.rearm_en),
        .evt      (evt)
    );

    irq_rst_ctrl_signal #(
        .PULSE_CYC (PULSE_CYC)
    ) u_signal (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_mode (ctl.pulse_mode),
        .evt        (evt),
        .irq_out    (irq_out)
    );

    irq_rst_ctrl_rstgate u_rstgate (
        .clk            (clk),
        .rst_n          (rst_n),
        .board_rst_req  (board_rst_req),
        .rst_block      (ctl.rst_block),
        .card_rst_force (ctl.card_rst_force),
        .board_rst_out  (board_rst_out),
        .card_rst_out   (card_rst_out)
    );

endmodule

// File: tb/tb_irq_rst_ctrl.sv
module tb_irq_rst_ctrl;

    localparam int N_SRC = 4;
    localparam int RCYC  = 100;
    localparam int PCYC  = 280;   // 250 MHz x 1.12 us

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic [N_SRC-1:0] irq_src = '0;
    logic        irq_out;
    logic        board_rst_req = 1'b0;
    logic        board_rst_out;
    logic        card_rst_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    irq_rst_ctrl #(
        .N_SRC      (N_SRC),
        .CLK_HZ     (64'd250_000_000),
        .RETRIG_CYC (RCYC)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_sel       (bus_sel),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .irq_src       (irq_src),
        .irq_out       (irq_out),
        .board_rst_req (board_rst_req),
        .board_rst_out (board_rst_out),
        .card_rst_out  (card_rst_out)
    );

    // Vector: {sel, wr, wdata, expected read after the cycle}
    localparam logic [33:0] VEC [0:6] = '{
        {1'b1, 1'b1, 16'hFFF5, 16'h0005},
        {1'b0, 1'b1, 16'h000F, 16'h0005},
        {1'b1, 1'b0, 16'h000A, 16'h0005},
        {1'b1, 1'b1, 16'h00FA, 16'h000A},
        {1'b1, 1'b1, 16'hAB00, 16'h0000},
        {1'b1, 1'b1, 16'h000C, 16'h000C},
        {1'b1, 1'b1, 16'h0000, 16'h0000}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 16'h0000;
    endtask

    task automatic reg_read(output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0;
        #0.5 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Count line transitions over n cycles.
    task automatic count_toggles(input int n, output int t);
        logic last;
        last = irq_out;
        t = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (irq_out != last) t++;
            last = irq_out;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        int tg;

        wait_n(5);
        rst_n = 1'b1;
        tick();

        // R1: reset state
        reg_read(rd);
        check("R1 register", rd, 16'h0000);
        check("R1 irq_out", irq_out, 1);
        check("R1 board_rst_out", board_rst_out, 0);
        check("R1 card_rst_out", card_rst_out, 0);

        // R2: vector table walk over the bus
        for (int v = 0; v < 7; v++) begin
            bus_sel = VEC[v][33]; bus_wr = VEC[v][32]; bus_wdata = VEC[v][31:16];
            tick();
            bus_wr = 1'b0; bus_wdata = 16'h0000;
            reg_read(rd);
            check($sformatf("R2 vector %0d", v), rd, VEC[v][15:0]);
        end
        reg_write(16'h0003);
        bus_sel = 1'b0;
        #0.5 check("R2 unselected read", bus_rdata, 16'h0000);
        reg_write(16'h0000);
        wait_n(3);

        // R3: level mode, first rising edge
        irq_src = 4'b0001;
        wait_n(2);
        check("R3 no change before third edge", irq_out, 1);
        tick();
        check("R3 toggled on third edge", irq_out, 0);
        // R3: second source rises
        irq_src = 4'b0011;
        wait_n(3);
        check("R3 second toggle", irq_out, 1);
        // R10: falling edge gives no event
        irq_src = 4'b0010;
        count_toggles(6, tg);
        check("R10 fall silent", tg, 0);
        // R10: three simultaneous rises give one event; R4: then holds
        irq_src = 4'b1111;
        count_toggles(6, tg);
        check("R10 one event for simultaneous rises", tg, 1);
        check("R10 level after", irq_out, 0);
        count_toggles(60, tg);
        check("R4 level holds while pending", tg, 0);
        irq_src = 4'b0000;
        wait_n(5);

        // R5: pulse mode idle high
        reg_write(16'h0002);
        check("R5 idle high", irq_out, 1);
        irq_src = 4'b0001;
        wait_n(2);
        check("R5 high before third edge", irq_out, 1);
        tick();
        check("R5 low on third edge", irq_out, 0);
        // R6: two events during the pulse
        wait_n(100);
        irq_src = 4'b0011;
        wait_n(50);
        irq_src = 4'b0111;
        wait_n(PCYC - 1 - 150);
        check("R5 still low at last cycle", irq_out, 0);
        tick();
        check("R5 high after width", irq_out, 1);
        tick();
        check("R6 held pulse starts after one high cycle", irq_out, 0);
        wait_n(PCYC - 1);
        check("R6 held pulse full width", irq_out, 0);
        tick();
        check("R6 held pulse ends", irq_out, 1);
        count_toggles(30, tg);
        check("R6 merged events give one pulse", tg, 0);
        irq_src = 4'b0000;
        wait_n(5);

        // R7: rearm in level mode
        reg_write(16'h0001);
        irq_src = 4'b0100;
        wait_n(3);
        check("R7 first toggle", irq_out, 1);
        count_toggles(250, tg);
        check("R7 rearm fires every interval", tg, 2);
        reg_write(16'h0000);
        count_toggles(300, tg);
        check("R7 no rearm when disabled", tg, 0);
        irq_src = 4'b0000;
        wait_n(5);

        // R8/R9: reset gating
        board_rst_req = 1'b1;
        #0.5;
        check("R8 pass through", board_rst_out, 1);
        check("R9 card follows board", card_rst_out, 1);
        reg_write(16'h0004);
        check("R8 blocked", board_rst_out, 0);
        check("R9 card follows blocked board", card_rst_out, 0);
        reg_write(16'h000C);
        check("R9 forced with board blocked", card_rst_out, 1);
        board_rst_req = 1'b0;
        #0.5;
        check("R9 forced without request", card_rst_out, 1);
        check("R8 no request", board_rst_out, 0);
        reg_write(16'h0000);
        check("R9 released", card_rst_out, 0);

        // R1: mid-run reset clears the register
        reg_write(16'h000F);
        rst_n = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        tick();
        reg_read(rd);
        check("R1 register after reset", rd, 16'h0000);
        check("R1 irq_out after reset", irq_out, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule